// File: doc/BRIEF.md
# Hybrid PAL/PLA Logic Block

This block is one logic block of a small programmable logic device. It forms sums of products over 36 logic inputs, where each input can be used in true or complemented form. It drives 16 macrocells. Each macrocell ORs five product terms that belong to it alone, through a fixed connection. It can also OR in any subset of a pool of 32 product terms shared by all macrocells, through a programmable OR plane. A macrocell therefore combines between 5 and 37 terms. Six control terms supply the asynchronous preset, asynchronous reset and output enable of the macrocells. Each control term can be set to act as a sum or as a product. Two of them can also clock the macrocell flip-flops in place of the global clock.

All configuration sits in a single shift chain. The chain is loaded one bit per clock while `cfg_load` is high. While loading, the macrocell outputs and enables are held inactive. The block also returns 32 feedback signals toward the device-wide interconnect: the 16 macrocell outputs and the 16 pad-side inputs.

Top module: `hybrid_logic_block`

## Requirements
- R1: While `cfg_load` is high, each rising `clk` edge shifts `cfg_din` into the top bit of the 9222-bit configuration chain and moves every other bit down by one. After a full load, the first bit shifted in sits at bit 0. With `cfg_load` low the chain holds its value. A low `rst_n` clears the whole chain to 0, which leaves all outputs at 0 and all enables at 1.
- R2: A product term occupies 72 configuration bits. Bit 2i includes input i in true form and bit 2i+1 includes it in complemented form. The term is the AND of the included literals. A term with no literal included evaluates to 0.
- R3: Product term p starts at chain bit 72*p. Terms 5m to 5m+4 belong to macrocell m and always feed its OR.
- R4: Shared terms are product terms 80 to 111. OR-plane bit 8064 + 32*m + j adds shared term j to macrocell m.
- R5: Control term c occupies 73 bits starting at 8576 + 73*c. The first 72 bits are literal bits coded as in R2, and the last bit selects the mode: 1 = sum (OR of included literals), 0 = product. In either mode, a term with no literal included evaluates to 0.
- R6: Each macrocell has a 13-bit field at 9014 + 13*m. Bit 0 = 1 selects the flip-flop output and bit 0 = 0 selects the combinational sum. Bit 1 inverts the sum before both paths.
- R7: Field bits [3:2] select the flip-flop clock: 1 = control term 0, 2 = control term 1, 0 or 3 = `clk`. A macrocell clocked by a control term captures on that term's rising edge and ignores `clk`.
- R8: Field bits [6:4] pick the preset term and bits [9:7] pick the reset term: code k (1..6) selects control term k-1, and 0 or 7 selects none. Preset forces the flip-flop to 1 and reset forces it to 0, both asynchronously. Reset wins when both are active.
- R9: Field bits [12:10] pick the output enable: 0 = always enabled, 7 = never enabled, k (1..6) = control term k-1.
- R10: `fb_out[15:0]` equals `mc_out` and `fb_out[31:16]` equals `io_in`.
- R11: While `cfg_load` is high, `mc_out` and `mc_oe` are all zero and the flip-flops hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global clock; also the configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset of configuration and flip-flops |
| cfg_load | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| lb_in | input | 36 | Logic inputs from the interconnect |
| io_in | input | 16 | Pad-side inputs returned as feedback |
| mc_out | output | 16 | Macrocell outputs |
| mc_oe | output | 16 | Macrocell output enables |
| fb_out | output | 32 | Feedback toward the interconnect |

## Verification
Three behaviours are the hardest to reach from the ports: macrocells clocked by a control term, asynchronous preset and reset, and reset winning over preset. Each needs a literal-built control term to rise while the data path is already steady. The directed tasks therefore change exactly one input bit per step. Each of those bits feeds a one-literal product term, so every clock edge, preset or reset edge appears in a known cycle without a glitch. The random configurations use product terms with one to three literals, so that terms are neither always false nor always true. A bench-side model then predicts every output, enable and feedback bit.

// File: rtl/lb_pkg.sv
package lb_pkg;

    // Per-macrocell configuration field; reg_en is bit 0 of the field.
    typedef struct packed {
        logic [2:0] oe_sel;
        logic [2:0] rst_sel;
        logic [2:0] pre_sel;
        logic [1:0] clk_sel;
        logic       inv;
        logic       reg_en;
    } mc_cfg_t;

    localparam int MC_CFG_W = $bits(mc_cfg_t);

    localparam logic [1:0] CK_CT_A = 2'd1;
    localparam logic [1:0] CK_CT_B = 2'd2;

    localparam logic [2:0] OE_ALWAYS = 3'd0;
    localparam logic [2:0] OE_NEVER  = 3'd7;

endpackage

// File: rtl/lb_cfg_chain.sv
module lb_cfg_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] bits_q
);

    typedef struct packed {
        logic [W-1:0] bits;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        if (shift_en) begin
            chain_d.bits = {din, chain_q.bits[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign bits_q = chain_q.bits;

endmodule

// File: rtl/lb_and_plane.sv
module lb_and_plane #(
    parameter int N_IN = 4,
    parameter int N_PT = 4
) (
    input  logic [2*N_IN-1:0]      lit,
    input  logic [N_PT*2*N_IN-1:0] mask,
    output logic [N_PT-1:0]        pt
);

    localparam int LW = 2 * N_IN;

    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        logic [LW-1:0] sel;
        assign sel   = mask[p*LW +: LW];
        // empty term reads as unused (0); otherwise every picked literal must be 1
        assign pt[p] = (|sel) & (&(lit | ~sel));
    end

endmodule

// File: rtl/lb_ctrl_terms.sv
module lb_ctrl_terms #(
    parameter int N_IN = 4,
    parameter int N_CT = 6
) (
    input  logic [2*N_IN-1:0]          lit,
    input  logic [N_CT*(2*N_IN+1)-1:0] cfg,
    output logic [N_CT-1:0]            ct
);

    localparam int LW   = 2 * N_IN;
    localparam int CT_W = LW + 1;

    for (genvar c = 0; c < N_CT; c++) begin : g_ct
        logic [LW-1:0] sel;
        logic          sum_mode;
        logic          or_val;
        logic          and_val;

        assign sel      = cfg[c*CT_W +: LW];
        assign sum_mode = cfg[c*CT_W + LW];
        assign or_val   = |(lit & sel);
        assign and_val  = (|sel) & (&(lit | ~sel));
        assign ct[c]    = sum_mode ? or_val : and_val;
    end

endmodule

// File: rtl/lb_macrocell.sv
module lb_macrocell
    import lb_pkg::*;
#(
    parameter int N_DED = 5,
    parameter int N_SHR = 32,
    parameter int N_CT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [N_DED-1:0] ded_pt,
    input  logic [N_SHR-1:0] shr_pt,
    input  logic [N_SHR-1:0] or_sel,
    input  logic [N_CT-1:0]  ct,
    input  mc_cfg_t          cfg,
    output logic             out,
    output logic             oe
);

    typedef struct packed {
        logic q;
    } cell_t;

    cell_t cell_d, cell_q;

    logic sum_val;
    logic d_val;
    logic mclk;
    logic clr;
    logic set;

    function automatic logic ct_pick(input logic [2:0] sel, input logic [N_CT-1:0] terms);
        logic r;
        r = 1'b0;
        for (int k = 0; k < N_CT; k++) begin
            if (int'(sel) == k + 1) begin
                r = terms[k];
            end
        end
        return r;
    endfunction

    assign sum_val = (|ded_pt) | (|(shr_pt & or_sel));
    assign d_val   = sum_val ^ cfg.inv;

    always_comb begin
        case (cfg.clk_sel)
            CK_CT_A: mclk = ct[0];
            CK_CT_B: mclk = ct[1];
            default: mclk = clk;
        endcase
    end

    assign clr = ~rst_n | ct_pick(cfg.rst_sel, ct);
    assign set = ct_pick(cfg.pre_sel, ct);

    always_comb begin
        cell_d = cell_q;
        if (!hold) begin
            cell_d.q = d_val;
        end
    end

    always_ff @(posedge mclk or posedge clr or posedge set) begin
        if (clr) begin
            cell_q <= '0;
        end else if (set) begin
            cell_q <= '1;
        end else begin
            cell_q <= cell_d;
        end
    end

    always_comb begin
        if (hold) begin
            out = 1'b0;
            oe  = 1'b0;
        end else begin
            out = cfg.reg_en ? cell_q.q : d_val;
            case (cfg.oe_sel)
                OE_ALWAYS: oe = 1'b1;
                OE_NEVER:  oe = 1'b0;
                default:   oe = ct_pick(cfg.oe_sel, ct);
            endcase
        end
    end

endmodule

// File: rtl/hybrid_logic_block.sv
module hybrid_logic_block
    import lb_pkg::*;
#(
    parameter int N_IN  = 36,
    parameter int N_MC  = 16,
    parameter int N_DED = 5,
    parameter int N_SHR = 32,
    parameter int N_CT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_din,
    input  logic [N_IN-1:0]   lb_in,
    input  logic [N_MC-1:0]   io_in,
    output logic [N_MC-1:0]   mc_out,
    output logic [N_MC-1:0]   mc_oe,
    output logic [2*N_MC-1:0] fb_out
);

    localparam int LW       = 2 * N_IN;
    localparam int N_DEDALL = N_MC * N_DED;
    localparam int N_PT     = N_DEDALL + N_SHR;
    localparam int PT_BITS  = N_PT * LW;
    localparam int OR_BASE  = PT_BITS;
    localparam int OR_BITS  = N_MC * N_SHR;
    localparam int CT_BASE  = OR_BASE + OR_BITS;
    localparam int CT_W     = LW + 1;
    localparam int CT_BITS  = N_CT * CT_W;
    localparam int MC_BASE  = CT_BASE + CT_BITS;
    localparam int CFG_W    = MC_BASE + N_MC * MC_CFG_W;

    logic [CFG_W-1:0] cfg_q;
    logic [LW-1:0]    lit;
    logic [N_PT-1:0]  pt_all;
    logic [N_CT-1:0]  ct;

    lb_cfg_chain #(
        .W (CFG_W)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_load),
        .din      (cfg_din),
        .bits_q   (cfg_q)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit[2*i]   = lb_in[i];
        assign lit[2*i+1] = ~lb_in[i];
    end

    lb_and_plane #(
        .N_IN (N_IN),
        .N_PT (N_PT)
    ) u_and (
        .lit  (lit),
        .mask (cfg_q[PT_BITS-1:0]),
        .pt   (pt_all)
    );

    lb_ctrl_terms #(
        .N_IN (N_IN),
        .N_CT (N_CT)
    ) u_ctl (
        .lit (lit),
        .cfg (cfg_q[CT_BASE +: CT_BITS]),
        .ct  (ct)
    );

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        mc_cfg_t mcfg;
        assign mcfg = mc_cfg_t'(cfg_q[MC_BASE + m*MC_CFG_W +: MC_CFG_W]);

        lb_macrocell #(
            .N_DED (N_DED),
            .N_SHR (N_SHR),
            .N_CT  (N_CT)
        ) u_mc (
            .clk    (clk),
            .rst_n  (rst_n),
            .hold   (cfg_load),
            .ded_pt (pt_all[m*N_DED +: N_DED]),
            .shr_pt (pt_all[N_DEDALL +: N_SHR]),
            .or_sel (cfg_q[OR_BASE + m*N_SHR +: N_SHR]),
            .ct     (ct),
            .cfg    (mcfg),
            .out    (mc_out[m]),
            .oe     (mc_oe[m])
        );
    end

    assign fb_out = {io_in, mc_out};

endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
    parameter int CFG_W = 16,
    parameter int N_MC  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_load,
    input logic              cfg_din,
    input logic [CFG_W-1:0]  cfg_q,
    input logic [N_MC-1:0]   io_in,
    input logic [N_MC-1:0]   mc_out,
    input logic [N_MC-1:0]   mc_oe,
    input logic [2*N_MC-1:0] fb_out
);

    // R1: new bit enters at the top of the chain
    assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cfg_q[CFG_W-1] == $past(cfg_din));

    // R1: remaining bits move down one place
    assert_shift_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> cfg_q[CFG_W-2:0] == $past(cfg_q[CFG_W-1:1]));

    // R1: chain frozen when not loading
    assert_chain_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg_q));

    // R11: outputs quiet during a load
    assert_load_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (mc_out == '0 && mc_oe == '0));

    // R10: feedback halves
    assert_fb_cells_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fb_out[N_MC-1:0] == mc_out);

    assert_fb_pads_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fb_out[2*N_MC-1:N_MC] == io_in);

endmodule

bind hybrid_logic_block lb_checker #(
    .CFG_W (CFG_W),
    .N_MC  (N_MC)
) u_lb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_load (cfg_load),
    .cfg_din  (cfg_din),
    .cfg_q    (cfg_q),
    .io_in    (io_in),
    .mc_out   (mc_out),
    .mc_oe    (mc_oe),
    .fb_out   (fb_out)
);

// File: tb/hybrid_logic_block_bench.sv
module hybrid_logic_block_bench;

    localparam int NIN     = 36;
    localparam int NMC     = 16;
    localparam int NDED    = 5;
    localparam int NSH     = 32;
    localparam int NCT     = 6;
    localparam int LW      = 2 * NIN;
    localparam int NPT     = NMC * NDED + NSH;
    localparam int OR_BASE = NPT * LW;
    localparam int CT_BASE = OR_BASE + NMC * NSH;
    localparam int CT_W    = LW + 1;
    localparam int MC_BASE = CT_BASE + NCT * CT_W;
    localparam int MCW     = 13;
    localparam int CFG_W   = MC_BASE + NMC * MCW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_load = 1'b0;
    logic            cfg_din = 1'b0;
    logic [NIN-1:0]  lb_in = '0;
    logic [NMC-1:0]  io_in = '0;
    logic [NMC-1:0]  mc_out;
    logic [NMC-1:0]  mc_oe;
    logic [2*NMC-1:0] fb_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [CFG_W-1:0] img;

    always #4 clk = ~clk;

    hybrid_logic_block u_hybrid_logic_block (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .lb_in    (lb_in),
        .io_in    (io_in),
        .mc_out   (mc_out),
        .mc_oe    (mc_oe),
        .fb_out   (fb_out)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // ---------------- configuration image helpers ----------------
    task automatic pt_lit(input int p, input int i, input bit neg);
        img[p*LW + 2*i + int'(neg)] = 1'b1;
    endtask

    task automatic ct_lit(input int c, input int i, input bit neg);
        img[CT_BASE + c*CT_W + 2*i + int'(neg)] = 1'b1;
    endtask

    task automatic ct_mode(input int c, input bit sum);
        img[CT_BASE + c*CT_W + LW] = sum;
    endtask

    task automatic or_on(input int m, input int j);
        img[OR_BASE + m*NSH + j] = 1'b1;
    endtask

    task automatic set_mc(input int m, input bit rg, input bit inv, input logic [1:0] ck,
                          input logic [2:0] pre, input logic [2:0] rs, input logic [2:0] oe);
        img[MC_BASE + m*MCW +: MCW] = {oe, rs, pre, ck, inv, rg};
    endtask

    // ---------------- reference model ----------------
    function automatic bit pt_val(input int p, input logic [NIN-1:0] v);
        bit any = 1'b0;
        bit ok  = 1'b1;
        for (int i = 0; i < NIN; i++) begin
            if (img[p*LW + 2*i])     begin any = 1'b1; if (!v[i]) ok = 1'b0; end
            if (img[p*LW + 2*i + 1]) begin any = 1'b1; if (v[i])  ok = 1'b0; end
        end
        return any && ok;
    endfunction

    function automatic bit ct_val(input int c, input logic [NIN-1:0] v);
        bit any = 1'b0;
        bit allv = 1'b1;
        bit anyv = 1'b0;
        int b = CT_BASE + c*CT_W;
        for (int i = 0; i < NIN; i++) begin
            if (img[b + 2*i])     begin any = 1'b1; if (v[i])  anyv = 1'b1; else allv = 1'b0; end
            if (img[b + 2*i + 1]) begin any = 1'b1; if (!v[i]) anyv = 1'b1; else allv = 1'b0; end
        end
        if (img[b + LW]) return anyv;
        return any && allv;
    endfunction

    function automatic logic [NMC-1:0] exp_sum(input logic [NIN-1:0] v);
        logic [NMC-1:0] r;
        for (int m = 0; m < NMC; m++) begin
            logic [MCW-1:0] f;
            bit s = 1'b0;
            f = img[MC_BASE + m*MCW +: MCW];
            for (int k = 0; k < NDED; k++) s |= pt_val(m*NDED + k, v);
            for (int j = 0; j < NSH; j++) if (img[OR_BASE + m*NSH + j]) s |= pt_val(NMC*NDED + j, v);
            r[m] = s ^ f[1];
        end
        return r;
    endfunction

    function automatic logic [NMC-1:0] exp_oe(input logic [NIN-1:0] v);
        logic [NMC-1:0] r;
        for (int m = 0; m < NMC; m++) begin
            logic [MCW-1:0] f;
            int s;
            f = img[MC_BASE + m*MCW +: MCW];
            s = int'(f[12:10]);
            if (s == 0)      r[m] = 1'b1;
            else if (s == 7) r[m] = 1'b0;
            else             r[m] = ct_val(s - 1, v);
        end
        return r;
    endfunction

    function automatic logic [NMC-1:0] reg_mask();
        logic [NMC-1:0] r;
        for (int m = 0; m < NMC; m++) r[m] = img[MC_BASE + m*MCW];
        return r;
    endfunction

    // ---------------- stimulus primitives ----------------
    task automatic load_cfg();
        for (int i = 0; i < CFG_W; i++) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_din  = img[i];
            if (i == CFG_W / 2) begin
                #1;
                chk("R11 mc_out during load", {16'h0, mc_out}, 32'h0);
                chk("R11 mc_oe during load", {16'h0, mc_oe}, 32'h0);
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
    endtask

    task automatic drive(input logic [NIN-1:0] v);
        @(negedge clk);
        lb_in = v;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [NIN-1:0] bitv(input int i);
        logic [NIN-1:0] r;
        r = '0;
        r[i] = 1'b1;
        return r;
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        io_in = 16'hA5C3;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset mc_out", {16'h0, mc_out}, 32'h0);
        chk("R1 R9 reset mc_oe", {16'h0, mc_oe}, 32'h0000FFFF);
        chk("R10 reset fb_out", fb_out, 32'hA5C30000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_dedicated();
        img = '0;
        pt_lit(0, 0, 1'b0); pt_lit(0, 1, 1'b1);
        pt_lit(3, 0, 1'b0); pt_lit(3, 0, 1'b1);          // contradictory term, always 0
        pt_lit(4, 2, 1'b0); pt_lit(4, 3, 1'b0); pt_lit(4, 4, 1'b0);
        pt_lit(1*NDED + 2, 5, 1'b1);
        set_mc(1, 1'b0, 1'b1, 2'd0, 3'd0, 3'd0, 3'd0);
        set_mc(3, 1'b0, 1'b1, 2'd0, 3'd0, 3'd0, 3'd0);  // empty sum, inverted
        load_cfg();
        drive(36'h0);
        chk("R3 R6 dedicated all-zero", {16'h0, mc_out}, 32'h0008);
        drive(36'h1);
        chk("R2 R3 in0 & ~in1", {16'h0, mc_out}, 32'h0009);
        drive(36'h3);
        chk("R2 complement literal blocks", {16'h0, mc_out}, 32'h0008);
        drive(36'h1C);
        chk("R3 fifth dedicated term", {16'h0, mc_out}, 32'h0009);
        drive(36'h20);
        chk("R6 polarity on macrocell 1", {16'h0, mc_out}, 32'h000A);
    endtask

    task automatic t_shared();
        img = '0;
        pt_lit(80, 10, 1'b0);
        pt_lit(111, 11, 1'b1); pt_lit(111, 12, 1'b0);
        or_on(3, 0); or_on(3, 31); or_on(7, 31);
        pt_lit(5*NDED + 2, 13, 1'b0);
        for (int k = 0; k < NDED; k++) pt_lit(9*NDED + k, 20 + k, 1'b0);
        for (int j = 0; j < NSH; j++) or_on(9, j);
        load_cfg();
        drive(36'h0);
        chk("R4 shared idle", {16'h0, mc_out}, 32'h0);
        drive(bitv(10));
        chk("R4 shared term 0", {16'h0, mc_out}, 32'h0208);
        drive(bitv(12));
        chk("R4 shared term 31 to two cells", {16'h0, mc_out}, 32'h0288);
        drive(bitv(11) | bitv(12));
        chk("R4 shared term 31 blocked", {16'h0, mc_out}, 32'h0);
        drive(bitv(13));
        chk("R3 dedicated next to pool", {16'h0, mc_out}, 32'h0020);
        drive(bitv(24));
        chk("R3 R4 37-term cell", {16'h0, mc_out}, 32'h0200);
    endtask

    task automatic t_ctrl();
        img = '0;
        ct_lit(3, 20, 1'b0); ct_lit(3, 21, 1'b1); ct_mode(3, 1'b1);
        ct_lit(4, 20, 1'b0); ct_lit(4, 21, 1'b0); ct_mode(4, 1'b0);
        ct_mode(2, 1'b1);                                 // empty sum term
        set_mc(6,  1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd4);
        set_mc(8,  1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd5);
        set_mc(9,  1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd7);
        set_mc(10, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd6);
        set_mc(11, 1'b0, 1'b0, 2'd0, 3'd0, 3'd0, 3'd3);
        load_cfg();
        drive(36'h0);
        chk("R5 R9 sum term via complement", {16'h0, mc_oe}, 32'hF0FF);
        drive(bitv(21));
        chk("R5 R9 sum term false", {16'h0, mc_oe}, 32'hF0BF);
        drive(bitv(20) | bitv(21));
        chk("R5 R9 product term true", {16'h0, mc_oe}, 32'hF1FF);
        drive(bitv(20));
        chk("R5 R9 product term false", {16'h0, mc_oe}, 32'hF0FF);
    endtask

    task automatic t_preset_reset();
        img = '0;
        pt_lit(4*NDED, 0, 1'b0);
        ct_lit(1, 10, 1'b0);
        ct_lit(2, 11, 1'b0);
        set_mc(4, 1'b1, 1'b0, 2'd0, 3'd2, 3'd3, 3'd0);
        load_cfg();
        drive(bitv(0));
        tick();
        chk("R6 registered capture 1", {31'h0, mc_out[4]}, 32'h1);
        drive(36'h0);
        chk("R6 register holds until edge", {31'h0, mc_out[4]}, 32'h1);
        tick();
        chk("R6 registered capture 0", {31'h0, mc_out[4]}, 32'h0);
        drive(bitv(10));
        chk("R8 async preset", {31'h0, mc_out[4]}, 32'h1);
        drive(36'h0);
        tick();
        chk("R8 preset released", {31'h0, mc_out[4]}, 32'h0);
        drive(bitv(0));
        tick();
        drive(bitv(0) | bitv(11));
        chk("R8 async reset", {31'h0, mc_out[4]}, 32'h0);
        tick();
        chk("R8 reset holds over clock", {31'h0, mc_out[4]}, 32'h0);
        drive(bitv(10));
        chk("R8 preset after reset", {31'h0, mc_out[4]}, 32'h1);
        drive(bitv(10) | bitv(11));
        chk("R8 reset beats preset", {31'h0, mc_out[4]}, 32'h0);
        tick();
        chk("R8 reset beats preset at edge", {31'h0, mc_out[4]}, 32'h0);
        drive(36'h0);
    endtask

    task automatic t_ct_clock();
        img = '0;
        pt_lit(2*NDED, 0, 1'b0);
        pt_lit(12*NDED, 1, 1'b0);
        ct_lit(0, 35, 1'b0);
        ct_lit(1, 34, 1'b0);
        set_mc(2,  1'b1, 1'b0, 2'd1, 3'd0, 3'd0, 3'd0);
        set_mc(12, 1'b1, 1'b0, 2'd2, 3'd0, 3'd0, 3'd0);
        load_cfg();
        drive(36'h0);
        drive(bitv(35));
        drive(bitv(35) | bitv(34));
        drive(36'h0);
        chk("R7 term clocks captured 0", {16'h0, mc_out}, 32'h0);
        drive(bitv(0) | bitv(1));
        tick(); tick();
        chk("R7 global clock ignored", {16'h0, mc_out}, 32'h0);
        drive(bitv(0) | bitv(1) | bitv(35));
        chk("R7 term 0 edge", {16'h0, mc_out}, 32'h0004);
        drive(bitv(0) | bitv(1) | bitv(35) | bitv(34));
        chk("R7 term 1 edge", {16'h0, mc_out}, 32'h1004);
        drive(bitv(35) | bitv(34));
        tick(); tick();
        chk("R7 data change without term edge", {16'h0, mc_out}, 32'h1004);
    endtask

    task automatic rand_img();
        img = '0;
        for (int p = 0; p < NPT; p++) begin
            if ($urandom_range(1, 0) == 1) begin
                int n = int'($urandom_range(3, 1));
                for (int k = 0; k < n; k++)
                    pt_lit(p, int'($urandom_range(NIN - 1, 0)), bit'($urandom_range(1, 0)));
            end
        end
        for (int c = 0; c < NCT; c++) begin
            int n = int'($urandom_range(2, 0));
            for (int k = 0; k < n; k++)
                ct_lit(c, int'($urandom_range(NIN - 1, 0)), bit'($urandom_range(1, 0)));
            ct_mode(c, bit'($urandom_range(1, 0)));
        end
        for (int m = 0; m < NMC; m++) begin
            for (int j = 0; j < NSH; j++)
                if ($urandom_range(3, 0) == 0) or_on(m, j);
            set_mc(m, bit'($urandom_range(1, 0)), bit'($urandom_range(1, 0)), 2'd0, 3'd0, 3'd0,
                   3'($urandom_range(7, 0)));
        end
    endtask

    task automatic t_random();
        for (int r = 0; r < 3; r++) begin
            logic [NMC-1:0] rm;
            rand_img();
            rm = reg_mask();
            load_cfg();
            for (int t = 0; t < 16; t++) begin
                logic [NIN-1:0] v;
                logic [NMC-1:0] e;
                v = {$urandom, $urandom};
                @(negedge clk);
                io_in = 16'($urandom);
                lb_in = v;
                #1;
                e = exp_sum(v);
                chk("R3 R4 R6 random combinational cells", {16'h0, mc_out & ~rm}, {16'h0, e & ~rm});
                chk("R5 R9 random enables", {16'h0, mc_oe}, {16'h0, exp_oe(v)});
                tick();
                chk("R6 random all cells after edge", {16'h0, mc_out}, {16'h0, e});
                chk("R10 random feedback", fb_out, {io_in, e});
            end
        end
    endtask

    task automatic t_reset_clears();
        img = '0;
        set_mc(0, 1'b0, 1'b1, 2'd0, 3'd0, 3'd0, 3'd7);
        load_cfg();
        drive(36'h0);
        chk("R1 loaded before reset", {16'h0, mc_out, mc_oe}, 32'h0001FFFE);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset clears configuration", {16'h0, mc_out, mc_oe}, 32'h0000FFFF);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd7));
        t_reset();
        t_dedicated();
        t_shared();
        t_ctrl();
        t_preset_reset();
        t_ct_clock();
        t_random();
        t_reset_clears();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule